// File: doc/BRIEF.md
# Multi-Mode Transport Output Clock Generator

This block produces the byte clock for the transport-stream output of a demodulator. It runs entirely on the fast master clock. A two-bit source code picks one of four origins for the output clock. The first is a tick stream derived from the recovered symbol rate. The second is a tick stream derived from the decimation ratio. The third is an integer division of the master clock by a programmable ratio plus six. The fourth is an external clock pin, which is synchronized into the master domain.

The output is a registered clock level plus a strobe one master cycle wide. The strobe marks each low-to-high transition, so downstream packet logic can use it as a clock enable. A small synchronous write port holds the source code and the division ratio. New settings wait in shadow registers and become active only at the next output rising edge. The exception is while the output is being held off in symbol mode. In that case the settings apply at once, because the output is already low.

Top module: `ts_clkgen`

## Requirements
- R1: During and right after a synchronous reset `oclk` and `oclk_rise` are low, the active source code is 00 (symbol-derived) and the ratio is 0.
- R2: A write with `cfg_addr`=0 loads the source code from `cfg_wdata[1:0]`, where bit 1 is the manual-division flag and bit 0 is the symbol-rate-disable flag. The codes are 00 symbol-derived, 01 decimation-derived, 10 programmable division and 11 external clock. A write with `cfg_addr`=1 loads the 8-bit ratio.
- R3: In source 10 the output period is ratio+6 master cycles, so it ranges from 6 to 261. The level is high for floor((ratio+6)/2) cycles and low for the rest.
- R4: In source 00 with `sym_lock` high, each `sym_tick` toggles `oclk` on the next clock edge, so a rising edge occurs on every second tick.
- R5: In source 00 with `sym_lock` low, `oclk` is forced low on the next edge and `sym_tick` has no effect.
- R6: In source 01 each `dec_tick` toggles `oclk`, and `sym_tick` is ignored.
- R7: In source 11, `ext_clk` passes through a two-flop synchronizer. The output goes high on each synchronized rising edge and low on each falling edge, so its period and high time match the external clock.
- R8: `oclk_rise` is high for exactly the one cycle in which `oclk` has just gone from low to high.
- R9: A new source code or ratio takes effect only at the next output rising edge. The period in progress finishes with the old settings, and the first period after that edge follows the new settings in full.
- R10: While the output is held off (source 00 without lock), written settings become active on the next edge. A switch to source 10 made this way gives its first rising edge two edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = source code, 1 = division ratio |
| cfg_wdata | input | 8 | Write data |
| sym_tick | input | 1 | Symbol-rate tick, one cycle wide |
| sym_lock | input | 1 | Symbol lock indication |
| dec_tick | input | 1 | Decimation-derived tick, one cycle wide |
| ext_clk | input | 1 | External clock, asynchronous |
| oclk | output | 1 | Output clock level |
| oclk_rise | output | 1 | One-cycle strobe on each output rising edge |

## Verification
A register write is captured on the edge that samples `cfg_we`. A tick or a change of lock moves `oclk` on the very next edge. A rising edge on `ext_clk` reaches `oclk` on the third edge after it is sampled. The bench drives inputs and samples outputs on the falling clock edge, so every tick or lock result is read at the first falling edge after the capturing edge. Period and high-time measurements start at a falling edge that shows `oclk_rise`. Any write is followed by one further edge before the bench looks for the rising edge that applies it. The held-off switch is checked at exactly the second falling edge after the write.

// File: rtl/ts_clkgen_pkg.sv
package ts_clkgen_pkg;

    // Output clock source code: bit 1 = manual division, bit 0 = symbol rate disabled
    typedef enum logic [1:0] {
        SRC_SYM = 2'b00,
        SRC_DEC = 2'b01,
        SRC_DIV = 2'b10,
        SRC_EXT = 2'b11
    } src_e;

    localparam logic ADDR_SRC   = 1'b0;
    localparam logic ADDR_RATIO = 1'b1;

endpackage

// File: rtl/ts_clkgen_regs.sv
module ts_clkgen_regs
    import ts_clkgen_pkg::*;
#(
    parameter int unsigned RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [RATIO_W-1:0] wr_data,
    output src_e               shadow_src,
    output logic [RATIO_W-1:0] shadow_ratio
);

    typedef struct packed {
        src_e               src;
        logic [RATIO_W-1:0] ratio;
    } regs_s;

    regs_s regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == ADDR_SRC) begin
                regs_d.src = src_e'(wr_data[1:0]);
            end else begin
                regs_d.ratio = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{src: SRC_SYM, ratio: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign shadow_src   = regs_q.src;
    assign shadow_ratio = regs_q.ratio;

    // R2: a ratio write lands in the shadow register on the capturing edge
    a_r2_ratio_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_RATIO) |=> shadow_ratio == $past(wr_data));

    // R2: a source write lands in the shadow register on the capturing edge
    a_r2_src_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_SRC) |=> shadow_src == src_e'($past(wr_data[1:0])));

endmodule

// File: rtl/ts_clkgen_extsync.sv
module ts_clkgen_extsync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    output logic ext_rise,
    output logic ext_fall
);

    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], ext_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    // The last synchronized stage compared with one further delayed copy
    assign ext_rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign ext_fall = ~chain_q[STAGES-1] & chain_q[STAGES];

    // R7: an edge event lasts a single cycle
    a_r7_rise_single: assert property (@(posedge clk) disable iff (rst)
        ext_rise |=> !ext_rise);

    a_r7_fall_single: assert property (@(posedge clk) disable iff (rst)
        ext_fall |=> !ext_fall);

endmodule

// File: rtl/ts_clkgen_core.sv
module ts_clkgen_core
    import ts_clkgen_pkg::*;
#(
    parameter int unsigned RATIO_W    = 8,
    parameter int unsigned DIV_OFFSET = 6,
    parameter int unsigned CNT_W      = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  src_e               shadow_src,
    input  logic [RATIO_W-1:0] shadow_ratio,
    input  logic               sym_tick,
    input  logic               sym_lock,
    input  logic               dec_tick,
    input  logic               ext_rise,
    input  logic               ext_fall,
    output logic               oclk,
    output logic               oclk_rise
);

    localparam logic [CNT_W-1:0] CNT_IDLE = '1;

    typedef struct packed {
        src_e               src;
        logic [RATIO_W-1:0] ratio;
        logic [CNT_W-1:0]   cnt;
        logic               lvl;
        logic               rise;
    } core_s;

    core_s core_d, core_q;

    logic [CNT_W-1:0] divisor;
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] cnt_run;
    logic             hold_off;
    logic             lvl_n;
    logic             rise_n;
    logic             commit;

    always_comb begin
        divisor  = CNT_W'(core_q.ratio) + CNT_W'(DIV_OFFSET);
        hi_len   = divisor >> 1;
        cnt_run  = (core_q.cnt >= divisor - 1'b1) ? '0 : core_q.cnt + 1'b1;
        hold_off = (core_q.src == SRC_SYM) && !sym_lock;

        unique case (core_q.src)
            SRC_SYM: lvl_n = hold_off ? 1'b0 : (core_q.lvl ^ sym_tick);
            SRC_DEC: lvl_n = core_q.lvl ^ dec_tick;
            SRC_DIV: lvl_n = (cnt_run < hi_len);
            SRC_EXT: lvl_n = ext_rise ? 1'b1 : (ext_fall ? 1'b0 : core_q.lvl);
            default: lvl_n = 1'b0;
        endcase

        rise_n = lvl_n & ~core_q.lvl;
        commit = rise_n | hold_off;

        core_d      = core_q;
        core_d.lvl  = lvl_n;
        core_d.rise = rise_n;

        if (commit) begin
            core_d.src   = shadow_src;
            core_d.ratio = shadow_ratio;
        end

        if (commit && shadow_src == SRC_DIV) begin
            // At a rising edge the new period starts with its first high cycle;
            // from hold-off the counter restarts so the next edge rises
            core_d.cnt = rise_n ? '0 : CNT_IDLE;
        end else if (core_q.src == SRC_DIV) begin
            core_d.cnt = cnt_run;
        end else begin
            core_d.cnt = CNT_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '{src: SRC_SYM, ratio: '0, cnt: CNT_IDLE, lvl: 1'b0, rise: 1'b0};
        end else begin
            core_q <= core_d;
        end
    end

    assign oclk      = core_q.lvl;
    assign oclk_rise = core_q.rise;

    // R5: without lock in symbol mode the output is low one edge later
    a_r5_holdoff_low: assert property (@(posedge clk) disable iff (rst)
        (core_q.src == SRC_SYM && !sym_lock) |=> !oclk);

    // R8: the strobe marks only a fresh low-to-high step
    a_r8_rise_edge: assert property (@(posedge clk) disable iff (rst)
        oclk_rise |-> (oclk && !$past(oclk)));

    a_r8_rise_seen: assert property (@(posedge clk) disable iff (rst)
        (oclk && !$past(oclk)) |-> oclk_rise);

    // R9: the active source only changes at an output rising edge or from hold-off
    a_r9_src_deferred: assert property (@(posedge clk) disable iff (rst)
        (core_q.src != $past(core_q.src)) |->
            (oclk_rise || $past(core_q.src == SRC_SYM && !sym_lock)));

    a_r9_ratio_deferred: assert property (@(posedge clk) disable iff (rst)
        (core_q.ratio != $past(core_q.ratio)) |->
            (oclk_rise || $past(core_q.src == SRC_SYM && !sym_lock)));

    // R3: the division counter stays inside the current period
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (core_q.src == SRC_DIV && core_q.cnt != CNT_IDLE) |-> (core_q.cnt < divisor));

endmodule

// File: rtl/ts_clkgen.sv
module ts_clkgen
    import ts_clkgen_pkg::*;
#(
    parameter int unsigned RATIO_W     = 8,
    parameter int unsigned DIV_OFFSET  = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [RATIO_W-1:0] cfg_wdata,
    input  logic               sym_tick,
    input  logic               sym_lock,
    input  logic               dec_tick,
    input  logic               ext_clk,
    output logic               oclk,
    output logic               oclk_rise
);

    localparam int unsigned MAX_DIV = (1 << RATIO_W) - 1 + DIV_OFFSET;
    localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);

    src_e               shadow_src;
    logic [RATIO_W-1:0] shadow_ratio;
    logic               ext_rise;
    logic               ext_fall;

    ts_clkgen_regs #(
        .RATIO_W (RATIO_W)
    ) regs_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (cfg_we),
        .wr_addr      (cfg_addr),
        .wr_data      (cfg_wdata),
        .shadow_src   (shadow_src),
        .shadow_ratio (shadow_ratio)
    );

    ts_clkgen_extsync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst      (rst),
        .ext_in   (ext_clk),
        .ext_rise (ext_rise),
        .ext_fall (ext_fall)
    );

    ts_clkgen_core #(
        .RATIO_W    (RATIO_W),
        .DIV_OFFSET (DIV_OFFSET),
        .CNT_W      (CNT_W)
    ) core_i (
        .clk          (clk),
        .rst          (rst),
        .shadow_src   (shadow_src),
        .shadow_ratio (shadow_ratio),
        .sym_tick     (sym_tick),
        .sym_lock     (sym_lock),
        .dec_tick     (dec_tick),
        .ext_rise     (ext_rise),
        .ext_fall     (ext_fall),
        .oclk         (oclk),
        .oclk_rise    (oclk_rise)
    );

    // R1: reset leaves the output idle
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!oclk_rise && (!oclk || !rst)));

endmodule

// File: tb/ts_clkgen_tb.sv
module ts_clkgen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;
    localparam int WAIT_LIM   = 2000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       sym_tick = 1'b0;
    logic       sym_lock = 1'b0;
    logic       dec_tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic       oclk;
    logic       oclk_rise;

    int checks = 0;
    int fails  = 0;
    bit ext_en = 1'b0;
    int ext_hi = 5;
    int ext_lo = 7;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_clkgen dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sym_tick  (sym_tick),
        .sym_lock  (sym_lock),
        .dec_tick  (dec_tick),
        .ext_clk   (ext_clk),
        .oclk      (oclk),
        .oclk_rise (oclk_rise)
    );

    function automatic int exp_div(int r);
        return r + 6;
    endfunction

    function automatic int exp_hi(int r);
        return (r + 6) / 2;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(bit addr, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_rise(string req);
        for (int i = 0; i < WAIT_LIM; i++) begin
            @(negedge clk);
            if (oclk_rise) return;
        end
        check(req, 0, 1);
    endtask

    // Starts at a falling edge that shows oclk_rise
    task automatic count_period(output int per, output int hi);
        per = 0; hi = 1;
        for (int i = 0; i < WAIT_LIM; i++) begin
            @(negedge clk);
            per++;
            if (oclk_rise) return;
            if (oclk) hi++;
        end
    endtask

    task automatic pulse_sym();
        sym_tick = 1'b1; @(negedge clk); sym_tick = 1'b0;
    endtask

    task automatic pulse_dec();
        dec_tick = 1'b1; @(negedge clk); dec_tick = 1'b0;
    endtask

    initial begin
        forever begin
            if (ext_en) begin
                ext_clk = 1'b1; repeat (ext_hi) @(negedge clk);
                ext_clk = 1'b0; repeat (ext_lo) @(negedge clk);
            end else begin
                ext_clk = 1'b0; @(negedge clk);
            end
        end
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", WDOG_CYC, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int per, hi, lvl, t, r_old, r_new;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 oclk in reset", int'(oclk), 0);
        check("R1 rise in reset", int'(oclk_rise), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 oclk after reset", int'(oclk), 0);

        // R5: no lock, symbol ticks ignored
        for (int i = 0; i < 5; i++) begin
            pulse_sym();
            check("R5 held off", int'(oclk), 0);
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        // R4/R8: locked symbol mode toggles per tick
        sym_lock = 1'b1;
        @(negedge clk);
        lvl = 0;
        for (int i = 0; i < 11; i++) begin
            repeat ($urandom_range(0, 3)) @(negedge clk);
            pulse_sym();
            lvl ^= 1;
            check("R4 toggle", int'(oclk), lvl);
            check("R8 rise strobe", int'(oclk_rise), lvl);
        end

        // R5: losing lock forces the output low
        sym_lock = 1'b0;
        @(negedge clk);
        check("R5 lock lost", int'(oclk), 0);

        // R2/R10: settings apply at once while held off
        wr(1'b1, 0);
        wr(1'b0, 2);
        @(negedge clk);
        check("R10 no rise yet", int'(oclk_rise), 0);
        @(negedge clk);
        check("R10 first rise", int'(oclk_rise), 1);
        count_period(per, hi);
        check("R3 period ratio 0", per, exp_div(0));
        check("R3 high ratio 0", hi, exp_hi(0));

        // R3: divisors 7 to 9
        for (int r = 1; r <= 3; r++) begin
            wr(1'b1, r);
            wait_rise("R3 rise");
            count_period(per, hi);
            check("R3 period", per, exp_div(r));
            check("R3 high", hi, exp_hi(r));
        end

        // R9: write mid-period, current period keeps old length
        r_old = 3;
        for (int k = 0; k < 4; k++) begin
            r_new = (k == 3) ? 255 : int'($urandom_range(4, 200));
            wait_rise("R9 rise");
            t = 0;
            repeat (2) begin @(negedge clk); t++; end
            @(negedge clk); t++;
            cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'(r_new);
            @(negedge clk); t++;
            cfg_we = 1'b0;
            for (int i = 0; i < WAIT_LIM && !oclk_rise; i++) begin
                @(negedge clk); t++;
            end
            check("R9 old period kept", t, exp_div(r_old));
            count_period(per, hi);
            check("R9 new period", per, exp_div(r_new));
            check("R3 new high", hi, exp_hi(r_new));
            r_old = r_new;
        end

        // R7: external clock
        ext_hi = 5; ext_lo = 7; ext_en = 1'b1;
        wr(1'b0, 3);
        wait_rise("R7 commit");
        wait_rise("R7 rise");
        wait_rise("R7 rise");
        count_period(per, hi);
        check("R7 period 12", per, 12);
        check("R7 high 5", hi, 5);
        ext_hi = 3; ext_lo = 4;
        repeat (3) wait_rise("R7 rise");
        count_period(per, hi);
        check("R7 period 7", per, 7);
        check("R7 high 3", hi, 3);

        // R6: decimation ticks, symbol ticks ignored
        wr(1'b0, 1);
        wait_rise("R6 commit");
        ext_en = 1'b0;
        sym_lock = 1'b1;
        lvl = 1;
        pulse_sym();
        check("R6 sym ignored", int'(oclk), lvl);
        for (int i = 0; i < 8; i++) begin
            repeat ($urandom_range(1, 4)) @(negedge clk);
            check("R6 stable between ticks", int'(oclk), lvl);
            pulse_dec();
            lvl ^= 1;
            check("R6 toggle", int'(oclk), lvl);
            check("R8 rise on dec", int'(oclk_rise), lvl);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule